// File: doc/BRIEF.md
# Direct-Mapped Branch Target Buffer

This block sits beside the instruction fetch stage and answers, in the same cycle, where fetch should go next. The current fetch address is presented every cycle. A slot chosen by the low address bits is read and its stored tag is compared with the upper address bits. If the slot matches and its two-bit direction counter leans taken, the block returns the target stored in that slot as the next fetch address. In every other case it returns the sequential address, the fetch address plus four.

Each slot holds a valid flag, a tag, a full-width target and a saturating direction counter. A resolve port reports the outcome of a branch once it executes: its address, whether it was taken and its actual target. A taken branch with no matching slot claims its slot and evicts whatever was there. A branch that matches trains the counter and refreshes the stored target. The number of slots is a parameter.

Top module: `btb_top`

## Requirements
- R1: While reset (`rst_n` low, synchronous) is applied at a clock edge, every slot becomes invalid, so every lookup after that edge misses until a new resolve installs an entry.
- R2: The slot index is fetch address bits [IDX_W+1:2] and the tag is bits [PC_W-1:IDX_W+2]. Bits [1:0] take no part in the lookup. `fe_hit` is high exactly when the indexed slot is valid and its tag equals the address tag.
- R3: On a miss, `fe_taken` is 0 and `fe_next_pc` equals `fe_pc + 4`.
- R4: On a hit, `fe_taken` equals bit 1 of the slot's counter. When it is set, `fe_next_pc` is the stored target. When it is clear, `fe_next_pc` is `fe_pc + 4`.
- R5: A taken resolve that misses writes its slot. The slot becomes valid with the resolve tag and target, and its counter is set to 2 (weakly taken). Any other branch held in that slot is evicted.
- R6: A not-taken resolve that misses changes no slot.
- R7: A resolve that hits moves the counter up by one if taken, saturating at 3, or down by one if not taken, saturating at 0. It also writes the resolve target into the slot. Counter encoding: 0 strongly not taken, 1 weakly not taken, 2 weakly taken, 3 strongly taken.
- R8: A resolve takes effect at the clock edge that samples it. A lookup in that same cycle still sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fe_pc | input | PC_W | Current fetch address |
| fe_hit | output | 1 | Indexed slot is valid and its tag matches |
| fe_taken | output | 1 | Redirect fetch to the stored target |
| fe_next_pc | output | PC_W | Next fetch address |
| rs_valid | input | 1 | A branch resolution is presented this cycle |
| rs_pc | input | PC_W | Address of the resolved branch |
| rs_taken | input | 1 | Actual outcome of the resolved branch |
| rs_target | input | PC_W | Actual target of the resolved branch |

## Verification
The bound checker enforces several rules on every cycle. A miss always falls through to the sequential address, and a redirect needs a hit. No slot is valid on the first cycle after reset. After any taken resolve, the resolved address hits on the next cycle. After any resolve, a redirect of that address goes to the newly written target. The exact counter values, saturation at both ends, evictions caused by index conflicts, the silence of not-taken misses and the same-cycle ordering of lookup and update can only be shown by the bench. It runs directed and random sequences against a behavioural model keyed by slot index.

// File: rtl/btb_pkg.sv
// Package: shared counter type and helpers for the branch target buffer.
// Assumes: the two-bit counter predicts taken when its upper bit is set.
package btb_pkg;
    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_WEAK_TAKEN = 2'b10;

    // Saturating step of the direction counter.
    function automatic ctr_t ctr_step(input ctr_t cur, input logic up);
        ctr_t nxt;
        if (up) begin
            nxt = (cur == 2'b11) ? cur : cur + 2'b01;
        end else begin
            nxt = (cur == 2'b00) ? cur : cur - 2'b01;
        end
        return nxt;
    endfunction
endpackage

// File: rtl/btb_store.sv
// Module: slot storage with two read ports and one write port.
// Assumes: only the valid flags need reset; tag, target and counter
// fields are written whenever a slot is made valid.
module btb_store #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 6,
    parameter int TAG_W = PC_W - IDX_W - 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_W-1:0]   rd_idx_a,
    output logic               rd_vld_a,
    output logic [TAG_W-1:0]   rd_tag_a,
    output logic [PC_W-1:0]    rd_tgt_a,
    output btb_pkg::ctr_t      rd_ctr_a,
    input  logic [IDX_W-1:0]   rd_idx_b,
    output logic               rd_vld_b,
    output logic [TAG_W-1:0]   rd_tag_b,
    output btb_pkg::ctr_t      rd_ctr_b,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [TAG_W-1:0]   wr_tag,
    input  logic [PC_W-1:0]    wr_tgt,
    input  btb_pkg::ctr_t      wr_ctr
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0]  vld_q;
    logic [TAG_W-1:0]  tag_q [DEPTH];
    logic [PC_W-1:0]   tgt_q [DEPTH];
    btb_pkg::ctr_t     ctr_q [DEPTH];

    // Valid flags: cleared by reset, set by any write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
        end
    end

    // Payload fields: written on any write, never reset.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
            tgt_q[wr_idx] <= wr_tgt;
            ctr_q[wr_idx] <= wr_ctr;
        end
    end

    // Asynchronous reads for the fetch port (a) and the resolve port (b).
    always_comb begin
        rd_vld_a = vld_q[rd_idx_a];
        rd_tag_a = tag_q[rd_idx_a];
        rd_tgt_a = tgt_q[rd_idx_a];
        rd_ctr_a = ctr_q[rd_idx_a];
        rd_vld_b = vld_q[rd_idx_b];
        rd_tag_b = tag_q[rd_idx_b];
        rd_ctr_b = ctr_q[rd_idx_b];
    end
endmodule

// File: rtl/btb_match.sv
// Module: tag comparator for one read port.
// Assumes: the stored tag is meaningful only when the valid flag is set.
module btb_match #(
    parameter int TAG_W = 24
) (
    input  logic             slot_vld,
    input  logic [TAG_W-1:0] slot_tag,
    input  logic [TAG_W-1:0] probe_tag,
    output logic             hit
);
    // A hit needs a live slot holding the same tag.
    always_comb hit = slot_vld && (slot_tag == probe_tag);
endmodule

// File: rtl/btb_update.sv
// Module: decides whether a resolve writes its slot and with which counter.
// Assumes: a not-taken branch that misses is never installed.
module btb_update (
    input  logic          rs_valid,
    input  logic          rs_taken,
    input  logic          rs_hit,
    input  btb_pkg::ctr_t cur_ctr,
    output logic          wr_en,
    output btb_pkg::ctr_t wr_ctr
);
    // Train on a hit, allocate weakly taken on a taken miss.
    always_comb begin
        wr_en  = rs_valid && (rs_hit || rs_taken);
        wr_ctr = rs_hit ? btb_pkg::ctr_step(cur_ctr, rs_taken)
                        : btb_pkg::CTR_WEAK_TAKEN;
    end
endmodule

// File: rtl/btb_top.sv
// Module: direct-mapped branch target buffer, lookup and resolve paths.
// Assumes: instruction addresses are word aligned in use; bits [1:0]
// are ignored for indexing and tagging.
module btb_top #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fe_pc,
    output logic            fe_hit,
    output logic            fe_taken,
    output logic [PC_W-1:0] fe_next_pc,
    input  logic            rs_valid,
    input  logic [PC_W-1:0] rs_pc,
    input  logic            rs_taken,
    input  logic [PC_W-1:0] rs_target
);
    localparam int TAG_W = PC_W - IDX_W - 2;

    logic [IDX_W-1:0] fe_idx, rs_idx;
    logic [TAG_W-1:0] fe_tag, rs_tag;
    logic             a_vld, b_vld, rs_hit, wr_en;
    logic [TAG_W-1:0] a_tag, b_tag;
    logic [PC_W-1:0]  a_tgt;
    btb_pkg::ctr_t    a_ctr, b_ctr, wr_ctr;

    // Split both addresses into slot index and tag.
    always_comb begin
        fe_idx = fe_pc[IDX_W+1:2];
        fe_tag = fe_pc[PC_W-1:IDX_W+2];
        rs_idx = rs_pc[IDX_W+1:2];
        rs_tag = rs_pc[PC_W-1:IDX_W+2];
    end

    btb_store #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_idx_a(fe_idx), .rd_vld_a(a_vld), .rd_tag_a(a_tag),
        .rd_tgt_a(a_tgt), .rd_ctr_a(a_ctr),
        .rd_idx_b(rs_idx), .rd_vld_b(b_vld), .rd_tag_b(b_tag),
        .rd_ctr_b(b_ctr),
        .wr_en(wr_en), .wr_idx(rs_idx), .wr_tag(rs_tag),
        .wr_tgt(rs_target), .wr_ctr(wr_ctr)
    );

    btb_match #(.TAG_W(TAG_W)) u_fe_match (
        .slot_vld(a_vld), .slot_tag(a_tag), .probe_tag(fe_tag), .hit(fe_hit)
    );

    btb_match #(.TAG_W(TAG_W)) u_rs_match (
        .slot_vld(b_vld), .slot_tag(b_tag), .probe_tag(rs_tag), .hit(rs_hit)
    );

    btb_update u_update (
        .rs_valid(rs_valid), .rs_taken(rs_taken), .rs_hit(rs_hit),
        .cur_ctr(b_ctr), .wr_en(wr_en), .wr_ctr(wr_ctr)
    );

    // Choose redirect or sequential next fetch address.
    always_comb begin
        fe_taken   = fe_hit && a_ctr[1];
        fe_next_pc = fe_taken ? a_tgt : fe_pc + PC_W'(4);
    end
endmodule

// File: rtl/btb_top_chk.sv
// Module: property checker bound to btb_top; observes ports only.
// Assumes: synchronous active-low reset held for at least one edge.
module btb_top_chk #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] fe_pc,
    input logic            fe_hit,
    input logic            fe_taken,
    input logic [PC_W-1:0] fe_next_pc,
    input logic            rs_valid,
    input logic [PC_W-1:0] rs_pc,
    input logic            rs_taken,
    input logic [PC_W-1:0] rs_target
);
    // R1
    reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !fe_hit);

    // R3
    miss_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fe_hit |-> (!fe_taken && fe_next_pc == fe_pc + PC_W'(4)));

    // R4
    redirect_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fe_taken |-> fe_hit);

    // R5
    taken_installs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && rs_taken) |=> ((fe_pc == $past(rs_pc)) |-> fe_hit));

    // R7
    target_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rs_valid |=> ((fe_pc == $past(rs_pc) && fe_taken)
                      |-> fe_next_pc == $past(rs_target)));
endmodule

bind btb_top btb_top_chk #(.PC_W(PC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .fe_pc(fe_pc), .fe_hit(fe_hit),
    .fe_taken(fe_taken), .fe_next_pc(fe_next_pc), .rs_valid(rs_valid),
    .rs_pc(rs_pc), .rs_taken(rs_taken), .rs_target(rs_target)
);

// File: tb/sim_btb_top.sv
// Bench: behavioural model keyed by slot index, compared every cycle.
module sim_btb_top;
    localparam int PC_W  = 32;
    localparam int IDX_W = 6;
    localparam int DEPTH = 1 << IDX_W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] fe_pc = '0;
    logic            fe_hit, fe_taken;
    logic [PC_W-1:0] fe_next_pc;
    logic            rs_valid = 1'b0;
    logic [PC_W-1:0] rs_pc = '0;
    logic            rs_taken = 1'b0;
    logic [PC_W-1:0] rs_target = '0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // Model: slot index -> full branch address, target, counter.
    logic [PC_W-1:0] m_pc  [int];
    logic [PC_W-1:0] m_tgt [int];
    int              m_ctr [int];

    always #2.5 clk = ~clk;

    btb_top #(.PC_W(PC_W), .IDX_W(IDX_W)) u0 (
        .clk(clk), .rst_n(rst_n), .fe_pc(fe_pc), .fe_hit(fe_hit),
        .fe_taken(fe_taken), .fe_next_pc(fe_next_pc), .rs_valid(rs_valid),
        .rs_pc(rs_pc), .rs_taken(rs_taken), .rs_target(rs_target)
    );

    function automatic int idx_of(input logic [PC_W-1:0] a);
        return int'((a >> 2) % DEPTH);
    endfunction

    function automatic bit m_hit(input logic [PC_W-1:0] a);
        int i = idx_of(a);
        return m_pc.exists(i) && ((m_pc[i] >> (IDX_W + 2)) == (a >> (IDX_W + 2)));
    endfunction

    // Drive one cycle, compare lookup outputs, then advance the model.
    task automatic step(input logic [PC_W-1:0] fpc, input bit rv,
                        input logic [PC_W-1:0] rpc, input bit rt,
                        input logic [PC_W-1:0] rtg, input string req);
        bit e_hit, e_tk;
        logic [PC_W-1:0] e_nx;
        int i;
        @(negedge clk);
        fe_pc = fpc; rs_valid = rv; rs_pc = rpc; rs_taken = rt; rs_target = rtg;
        #1;
        e_hit = m_hit(fpc);
        e_tk  = e_hit && (m_ctr[idx_of(fpc)] >= 2);
        e_nx  = e_tk ? m_tgt[idx_of(fpc)] : fpc + 32'd4;
        n_tests++;
        if (fe_hit !== e_hit || fe_taken !== e_tk || fe_next_pc !== e_nx) begin
            n_fail++;
            $display("FAIL %s pc=%h: hit/taken/next got %b/%b/%h expected %b/%b/%h",
                     req, fpc, fe_hit, fe_taken, fe_next_pc, e_hit, e_tk, e_nx);
        end
        @(posedge clk);
        if (rv) begin
            i = idx_of(rpc);
            if (m_hit(rpc)) begin
                m_ctr[i] = rt ? ((m_ctr[i] < 3) ? m_ctr[i] + 1 : 3)
                              : ((m_ctr[i] > 0) ? m_ctr[i] - 1 : 0);
                m_tgt[i] = rtg;
            end else if (rt) begin
                m_pc[i] = rpc; m_tgt[i] = rtg; m_ctr[i] = 2;
            end
        end
    endtask

    task automatic look(input logic [PC_W-1:0] fpc, input string req);
        step(fpc, 1'b0, '0, 1'b0, '0, req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; rs_valid = 1'b0;
        @(posedge clk); @(posedge clk);
        #1 rst_n = 1'b1;
        m_pc.delete(); m_tgt.delete(); m_ctr.delete();
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    localparam logic [PC_W-1:0] A  = 32'h0000_1040;  // index 16
    localparam logic [PC_W-1:0] B  = 32'h0000_2040;  // same index, other tag
    localparam logic [PC_W-1:0] TA = 32'h0000_8000;
    localparam logic [PC_W-1:0] TB = 32'h0000_9000;

    initial begin
        do_reset();
        look(A, "R1");
        look(32'h0, "R1");
        // R6: not-taken miss installs nothing
        step(A, 1'b1, A, 1'b0, TA, "R6");
        look(A, "R6");
        // R5: taken miss allocates weakly taken
        step(A, 1'b1, A, 1'b1, TA, "R5");
        look(A, "R5");
        look(A | 32'h3, "R2");          // low bits ignored
        look(A + 32'h4, "R2");          // neighbour slot misses
        // R7: train up to saturation, target refreshed
        step(A, 1'b1, A, 1'b1, TA + 32'h10, "R8");  // same-cycle sees old
        step(A, 1'b1, A, 1'b1, TA + 32'h20, "R7");
        look(A, "R7");
        // R7 / R4: train down to 0 and saturate
        step(A, 1'b1, A, 1'b0, TA, "R7");
        step(A, 1'b1, A, 1'b0, TA, "R4");
        look(A, "R4");
        step(A, 1'b1, A, 1'b0, TA, "R7");
        step(A, 1'b1, A, 1'b0, TA, "R7");
        look(A, "R7");
        step(A, 1'b1, A, 1'b1, TA, "R7");
        step(A, 1'b1, A, 1'b1, TA, "R4");
        look(A, "R4");
        // R5: conflicting branch evicts
        step(B, 1'b1, B, 1'b1, TB, "R5");
        look(B, "R5");
        look(A, "R5");
        // Random traffic over a small pool to force conflicts
        for (int k = 0; k < 400; k++) begin
            logic [PC_W-1:0] p, q;
            p = {20'h0, 2'(($urandom % 3)), 8'h0, 2'(($urandom % 4))} << 0;
            p = (32'(($urandom % 3)) << (IDX_W + 2)) | (32'(($urandom % 4)) << 2);
            q = (32'(($urandom % 3)) << (IDX_W + 2)) | (32'(($urandom % 4)) << 2);
            step(p, 1'($urandom % 2), q, 1'($urandom % 2),
                 32'($urandom) & 32'hFFFF_FFFC, "R7");
        end
        // R1: a second reset clears everything
        step(A, 1'b1, A, 1'b1, TA, "R5");
        do_reset();
        look(A, "R1");
        look(32'h0, "R1");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule